// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Integer Core

This block is a small processor that completes one instruction per clock. The program counter addresses an internal instruction store. The fetched 32-bit word is decoded in one of three fixed layouts: register, immediate or jump. Two source operands are read from a 32 x 32-bit register file. In the same cycle the block computes the result, performs the data-memory access, writes the destination register and selects the next program counter.

The instruction store is filled through a simple write port while the core is held in reset. The state of the core is observed through two ports: the current program counter, and a combinational read port into the register file.

The supported operations are register add, subtract, signed set-less-than and logical right shift; immediate add; word load and word store; branch-if-equal and branch-if-not-equal; and an unconditional jump.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and every register reads 0. After release, `pc_o` advances by one instruction (4) per clock for any instruction that does not redirect flow.
- R2: An instruction with opcode field [31:26] = 0 is register-format, with rs in [25:21], rt in [20:16] and rd in [15:11]. Function field [5:0] = 32 writes rs+rt to rd. Function field 34 writes rs-rt to rd.
- R3: Register-format function 42 writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R4: Register-format function 2 writes rt shifted right logically by the shift field [10:6] to rd.
- R5: Opcode 8 writes rs plus the sign-extended 16-bit constant [15:0] to rt.
- R6: Opcode 43 stores rt to the word at byte address rs + sign-extended constant. Opcode 35 loads that word into rt. Such addresses have their two low bits at zero.
- R7: Opcode 4 (equal) and opcode 5 (not equal) compare rs with rt. When the branch is taken, the next PC is PC+4 + (sign-extended constant x 4). Otherwise it is PC+4.
- R8: Opcode 2 sets the next PC to {PC+4[31:28], field[25:0], 2'b00}. A jump to its own address holds the PC there.
- R9: Register 0 always reads 0, and any write to it is discarded.
- R10: Asserting `prog_we` writes `prog_data` into instruction word `prog_addr` at the clock edge. `dbg_val` shows register `dbg_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | IMEM_AW | Instruction word index to write |
| prog_data | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter (byte address) |
| dbg_sel | input | 5 | Register index to observe |
| dbg_val | output | 32 | Contents of register `dbg_sel` |

## Verification
The main stimulus is a counted loop. It mixes register adds, immediate adds, set-less-than and a backward branch, and finishes with a shift. Its final register values and the exact cycle at which it reaches the halt address separate a correct loop count and branch offset from an off-by-one one.

A second sequence follows the loop. It makes a negative value by subtraction, passes it through a store and a load, and compares it with signed set-less-than. This tells signed comparison apart from unsigned comparison, and shows whether memory data is returned intact. A taken forward branch, a not-taken branch, a jump over a skipped instruction, and a write aimed at register 0 each leave a distinct register value when the redirect or the discard fails.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [IMEM_AW-1:0] prog_addr,
  input  logic [31:0]        prog_data,
  output logic [31:0]        pc_o,
  input  logic [4:0]         dbg_sel,
  output logic [31:0]        dbg_val
);
  localparam int IMEM_N = 1 << IMEM_AW;
  localparam int DMEM_N = 1 << DMEM_AW;
  localparam logic [5:0] OP_RT = 6'd0, OP_J = 6'd2, OP_BEQ = 6'd4, OP_BNE = 6'd5,
                         OP_ADDI = 6'd8, OP_LW = 6'd35, OP_SW = 6'd43;
  localparam logic [5:0] FN_SRL = 6'd2, FN_ADD = 6'd32, FN_SUB = 6'd34, FN_SLT = 6'd42;

  logic [31:0] imem [IMEM_N];
  logic [31:0] dmem [DMEM_N];
  logic [31:0] rf   [32];
  logic [31:0] pc, instr;

  assign instr = imem[pc[IMEM_AW+1:2]];

  logic [5:0] op, fn;
  logic [4:0] rs, rt, rd, sh;
  assign op = instr[31:26];
  assign rs = instr[25:21];
  assign rt = instr[20:16];
  assign rd = instr[15:11];
  assign sh = instr[10:6];
  assign fn = instr[5:0];

  logic is_add, is_sub, is_slt, is_srl, is_addi, is_lw, is_sw, is_beq, is_bne, is_j;
  assign is_add  = (op == OP_RT) && (fn == FN_ADD);
  assign is_sub  = (op == OP_RT) && (fn == FN_SUB);
  assign is_slt  = (op == OP_RT) && (fn == FN_SLT);
  assign is_srl  = (op == OP_RT) && (fn == FN_SRL);
  assign is_addi = op == OP_ADDI;
  assign is_lw   = op == OP_LW;
  assign is_sw   = op == OP_SW;
  assign is_beq  = op == OP_BEQ;
  assign is_bne  = op == OP_BNE;
  assign is_j    = op == OP_J;

  logic [31:0] a, b, simm, ea, alu, wdata;
  assign a    = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign b    = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign simm = {{16{instr[15]}}, instr[15:0]};
  assign ea   = a + simm;

  always_comb begin
    alu = a + simm;
    if (is_add) alu = a + b;
    else if (is_sub) alu = a - b;
    else if (is_slt) alu = {31'd0, $signed(a) < $signed(b)};
    else if (is_srl) alu = b >> sh;
  end

  logic        rwr;
  logic [4:0]  wa;
  assign rwr   = is_add | is_sub | is_slt | is_srl | is_addi | is_lw;
  assign wa    = (op == OP_RT) ? rd : rt;
  assign wdata = is_lw ? dmem[ea[DMEM_AW+1:2]] : alu;

  logic [31:0] pc4, pc_br, pc_nx;
  logic        take;
  assign pc4   = pc + 32'd4;
  assign pc_br = pc4 + {simm[29:0], 2'b00};
  assign take  = (is_beq && (a == b)) || (is_bne && (a != b));
  assign pc_nx = is_j ? {pc4[31:28], instr[25:0], 2'b00} : (take ? pc_br : pc4);

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= 32'd0;
    else pc <= pc_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (rwr && (wa != 5'd0)) begin
      rf[wa] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && is_sw) dmem[ea[DMEM_AW+1:2]] <= b;
  end

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  assign pc_o    = pc;
  assign dbg_val = (dbg_sel == 5'd0) ? 32'd0 : rf[dbg_sel];

  // R1
  reset_pc_chk: assert property (@(posedge clk) !rst_n |=> pc_o == 32'd0);
  // R1
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_j || is_beq || is_bne) |=> pc_o == $past(pc_o) + 32'd4);
  // R7
  branch_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pc_o == $past(pc_o) + 32'd4 + {$past(simm[29:0]), 2'b00});
  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_j |=> pc_o[27:0] == {$past(instr[25:0]), 2'b00});
  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rwr && wa == 5'd0) |=> rf[0] == 32'd0);
  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_sw |=> dmem[$past(ea[DMEM_AW+1:2])] == $past(b));
  // R6
  mem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lw || is_sw) |-> (ea[1:0] == 2'b00 && ea < DMEM_N * 4));
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
  localparam int IMEM_AW = 6;
  localparam int HALT_PC = 84;
  localparam int HALT_CYC = 29;

  logic clk = 1'b0, rst_n = 1'b0, prog_we = 1'b0;
  logic [IMEM_AW-1:0] prog_addr = '0;
  logic [31:0] prog_data = '0, pc_o, dbg_val;
  logic [4:0] dbg_sel = '0;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  sc_core #(.IMEM_AW(IMEM_AW), .DMEM_AW(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pc_o(pc_o), .dbg_sel(dbg_sel), .dbg_val(dbg_val));

  localparam logic [31:0] PROG [22] = '{
    32'h00004020, 32'h00004820, 32'h200A0003, 32'h01094020,
    32'h21080001, 32'h21290001, 32'h012A582A, 32'h1560FFFB,
    32'h00084042, 32'h000A6022, 32'hAC0C0008, 32'h8C0D0008,
    32'h0180702A, 32'h11AC0001, 32'h200F0063, 32'h20000005,
    32'h2010FFFF, 32'h14000005, 32'h20110007, 32'h08000015,
    32'h20110001, 32'h08000015};

  // {requirement number, register, expected value}
  localparam logic [44:0] EXPECT [12] = '{
    {8'd4, 5'd8,  32'd3},          // R4 srl of k=6
    {8'd5, 5'd9,  32'd3},          // R5 loop counter
    {8'd5, 5'd10, 32'd3},          // R5 addi constant
    {8'd3, 5'd11, 32'd0},          // R3 3<3 false
    {8'd2, 5'd12, 32'hFFFFFFFD},   // R2 sub 0-3
    {8'd6, 5'd13, 32'hFFFFFFFD},   // R6 sw/lw round trip
    {8'd3, 5'd14, 32'd1},          // R3 signed -3<0
    {8'd7, 5'd15, 32'd0},          // R7 beq taken skips write
    {8'd9, 5'd0,  32'd0},          // R9 write to r0 discarded
    {8'd5, 5'd16, 32'hFFFFFFFF},   // R5 sign-extended -1
    {8'd7, 5'd17, 32'd7},          // R7 bne not taken
    {8'd8, 5'd2,  32'd0}};         // R8 untouched reg

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int cyc;
    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = IMEM_AW'(i); prog_data = PROG[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    dbg_sel = 5'd8;
    #1;
    check(1, pc_o, 32'd0);        // R1 reset pc
    check(1, dbg_val, 32'd0);     // R1 reset register
    rst_n = 1'b1;
    @(negedge clk);
    check(10, pc_o, 32'd4);       // R10 loaded word executed, R1 advance
    cyc = 1;
    while (pc_o != HALT_PC && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    check(7, cyc, HALT_CYC);      // R7 R8 branch/jump path length
    for (int i = 0; i < 12; i++) begin
      dbg_sel = EXPECT[i][36:32];
      #1;
      check(int'(EXPECT[i][44:37]), dbg_val, EXPECT[i][31:0]);
    end
    repeat (3) @(negedge clk);
    check(8, pc_o, HALT_PC);      // R8 self jump holds
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule